// File: doc/BRIEF.md
# Power Register Command Engine

This engine sits on the processor side of a command mailbox and carries out power-controller register commands against a private file of 8-bit registers. A command arrives as a one-cycle `start` pulse. The pulse comes with a command code, a command id, a byte count and a 16-byte payload. The engine checks that the command code, the id and the count fit together before it touches any register. It then walks through the listed registers one per clock. It writes them, reads them, or merges new bits into one of them under a mask.

The payload begins with the register addresses as 16-bit values, low byte first. For a write, one data byte per register follows the address list. For a masked update, a value byte and a mask byte follow the single address. A read places its results in a 16-byte result buffer. The engine ends every command, accepted or rejected, with a one-cycle `done` pulse that carries an error flag and an error code.

Top module: `pwr_reg_engine`

## Requirements
- R1: `start` is taken only when `busy` is low. While `busy` is high, `start` is ignored. The code, id, count and payload are captured when `start` is taken, so later changes to those inputs have no effect on the command in progress.
- R2: A command code other than 0xFF is rejected with `err`=1 and `err_code`=0x01. No register is accessed, `rbuf` is left unchanged, and `done` is high in the cycle after the edge that took `start`.
- R3: With code 0xFF, a command id other than 0 (write), 1 (read) or 2 (masked update) is rejected with `err_code`=0x02. The code check wins over the id check.
- R4: A count that does not fit the operation is rejected with `err_code`=0x03 and no register access. A write needs 3n, a read needs 2n (n from 1 to 5), and a masked update needs exactly 4. A zero count is always rejected.
- R5: A write of n registers takes address k from payload bytes 2k (low) and 2k+1 (high), and its data from byte 2n+k.
- R6: A read of n registers puts the value of the k-th listed register into `rbuf` byte k (bits 8k+7:8k). Bytes n to 15 are cleared to zero.
- R7: A masked update takes its address from bytes 0 and 1, the value from byte 2 and the mask from byte 3. The new register content is (old AND NOT mask) OR (value AND mask).
- R8: Registers are accessed in list order, one per clock, so a repeated address in a write list ends with its later data. If `start` is taken at edge 0, `busy` is high after edges 0 to n-1, and `done` is high for exactly one cycle after edge n. A rejected command raises `done` after edge 0 and never raises `busy`.
- R9: Only the low REG_AW bits of an address (6 by default, so 64 registers) select a register. The upper bits are ignored, so addresses that differ only there reach the same register.
- R10: After reset, every register and every byte of `rbuf` is zero, and `busy`, `done`, `err` and `err_code` are zero.
- R11: `err` and `err_code` keep their value until the next `start` is taken. A successful command leaves both at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle command request |
| cmd_code | input | 8 | Command code, 0xFF for register access |
| cmd_id | input | 4 | Operation: 0 write, 1 read, 2 masked update |
| size | input | 8 | Payload byte count |
| wbuf | input | 128 | Payload, byte b at bits 8b+7:8b |
| busy | output | 1 | Register accesses in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command was rejected |
| err_code | output | 8 | 0 ok, 1 bad code, 2 bad id, 3 bad count |
| rbuf | output | 128 | Read results, byte k at bits 8k+7:8k |

## Verification
Completion of one command and acceptance of the next can fall in the same cycle. `done` is high with `busy` low, so a `start` held in that cycle must be taken while the finishing command's results are still on the outputs. The bench usually issues the next command at the very negative edge where it sees `done`. It then judges the new command's latency, error fields and read data against its own register model, so any lost or doubled acceptance shows up as a wrong latency or wrong data. A masked update also reads and writes its register in one cycle, and a later read of that register judges the merge.

// File: rtl/pwr_eng_pkg.sv
// Package: shared constants and types for the power register command engine.
// Assumes: a single command code selects register access; error codes are fixed.
package pwr_eng_pkg;

    localparam logic [7:0] PCTL_CODE = 8'hFF;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_RD  = 2'd1,
        OP_RMW = 2'd2
    } op_e;

    localparam logic [7:0] EC_NONE = 8'h00;
    localparam logic [7:0] EC_CODE = 8'h01;
    localparam logic [7:0] EC_ID   = 8'h02;
    localparam logic [7:0] EC_SIZE = 8'h03;

endpackage

// File: rtl/pwr_eng_decode.sv
// Module: pwr_eng_decode
// Checks a command's code, id and byte count, and derives the operation and
// the register count. It is purely combinational and works on the raw
// command inputs. Assumes: the code check outranks the id check, which
// outranks the count check.
module pwr_eng_decode
    import pwr_eng_pkg::*;
#(
    parameter int MAX_REGS = 5,
    parameter int CNT_W    = $clog2(MAX_REGS + 1)
) (
    input  logic [7:0]       cmd_code,
    input  logic [3:0]       cmd_id,
    input  logic [7:0]       size,
    output logic             ok,
    output op_e              op,
    output logic [CNT_W-1:0] cnt,
    output logic [7:0]       ec
);

    logic id_bad;

    // Purpose: map the id to an operation and find the register count that the size implies.
    always_comb begin
        op     = OP_WR;
        cnt    = '0;
        id_bad = 1'b0;
        case (cmd_id)
            4'd0: begin
                op = OP_WR;
                for (int k = 1; k <= MAX_REGS; k++)
                    if (size == 8'(3 * k)) cnt = CNT_W'(k);
            end
            4'd1: begin
                op = OP_RD;
                for (int k = 1; k <= MAX_REGS; k++)
                    if (size == 8'(2 * k)) cnt = CNT_W'(k);
            end
            4'd2: begin
                op = OP_RMW;
                if (size == 8'd4) cnt = CNT_W'(1);
            end
            default: id_bad = 1'b1;
        endcase
    end

    // Purpose: rank the error causes and flag a valid command.
    always_comb begin
        if (cmd_code != PCTL_CODE) ec = EC_CODE;
        else if (id_bad)           ec = EC_ID;
        else if (cnt == '0)        ec = EC_SIZE;
        else                       ec = EC_NONE;
        ok = (ec == EC_NONE);
    end

endmodule

// File: rtl/pwr_eng_regfile.sv
// Module: pwr_eng_regfile
// An 8-bit register file with one address port. The read is combinational
// and the write is clocked. Assumes: at most one access per cycle; every
// entry clears to zero on reset.
module pwr_eng_regfile #(
    parameter int REG_AW = 6,
    localparam int DEPTH = 1 << REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0] mem [DEPTH];

    // Purpose: clear the storage on reset and take a write when asked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Purpose: give the addressed entry back without delay.
    always_comb rdata = mem[addr];

endmodule

// File: rtl/pwr_eng_seq.sv
// Module: pwr_eng_seq
// Captures an accepted command and steps through its register list, one
// access per clock. It fills the result buffer for reads, merges under the
// mask for updates, and pulses done at the end. Assumes: the decode outputs
// are valid in the cycle that start is high; the payload holds at most
// BUF_BYTES bytes.
module pwr_eng_seq
    import pwr_eng_pkg::*;
#(
    parameter int MAX_REGS  = 5,
    parameter int BUF_BYTES = 16,
    parameter int REG_AW    = 6,
    parameter int CNT_W     = $clog2(MAX_REGS + 1),
    localparam int BI_W     = $clog2(BUF_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   ok,
    input  op_e                    op,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [7:0]             ec,
    input  logic [8*BUF_BYTES-1:0] wbuf,
    input  logic [7:0]             rd_data,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [7:0]             err_code,
    output logic [8*BUF_BYTES-1:0] rbuf,
    output logic                   rf_we,
    output logic [REG_AW-1:0]      rf_addr,
    output logic [7:0]             rf_wdata
);

    op_e              op_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic [7:0]       pay [BUF_BYTES];
    logic [7:0]       rb  [BUF_BYTES];
    logic [BI_W-1:0]  lo_i, hi_i, dat_i;
    logic             accept, last;

    // Purpose: work out the payload byte positions for the current list entry.
    always_comb begin
        lo_i  = BI_W'({idx_q, 1'b0});
        hi_i  = lo_i + 1'b1;
        dat_i = BI_W'({cnt_q, 1'b0}) + BI_W'(idx_q);
    end

    // Purpose: drive the register file port for the current access.
    always_comb begin
        rf_addr  = REG_AW'({pay[hi_i], pay[lo_i]});
        rf_we    = busy && (op_q != OP_RD);
        if (op_q == OP_RMW)
            rf_wdata = (rd_data & ~pay[3]) | (pay[2] & pay[3]);
        else
            rf_wdata = pay[dat_i];
    end

    // Purpose: decide whether start is taken and whether this access is the last one.
    always_comb begin
        accept = start && !busy;
        last   = (idx_q == CNT_W'(cnt_q - 1'b1));
    end

    // Purpose: capture commands, step the list index and produce the completion fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= 8'h00;
            op_q     <= OP_WR;
            cnt_q    <= '0;
            idx_q    <= '0;
            for (int b = 0; b < BUF_BYTES; b++) begin
                pay[b] <= 8'h00;
                rb[b]  <= 8'h00;
            end
        end else begin
            done <= 1'b0;
            if (accept) begin
                err      <= !ok;
                err_code <= ec;
                if (ok) begin
                    busy  <= 1'b1;
                    idx_q <= '0;
                    op_q  <= op;
                    cnt_q <= cnt;
                    for (int b = 0; b < BUF_BYTES; b++) begin
                        pay[b] <= wbuf[8*b +: 8];
                        if (op == OP_RD) rb[b] <= 8'h00;
                    end
                end else begin
                    done <= 1'b1;
                end
            end else if (busy) begin
                if (op_q == OP_RD) rb[idx_q] <= rd_data;
                idx_q <= idx_q + 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Purpose: pack the result bytes onto the output bus.
    always_comb begin
        for (int b = 0; b < BUF_BYTES; b++) rbuf[8*b +: 8] = rb[b];
    end

endmodule

// File: rtl/pwr_reg_engine.sv
// Module: pwr_reg_engine (top)
// The power register command engine. It links the command check, the access
// sequencer and the register file. Assumes: the mailbox presents a command
// with a one-cycle start and reads the results once done pulses.
module pwr_reg_engine
    import pwr_eng_pkg::*;
#(
    parameter int MAX_REGS  = 5,
    parameter int BUF_BYTES = 16,
    parameter int REG_AW    = 6,
    localparam int CNT_W    = $clog2(MAX_REGS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [7:0]             cmd_code,
    input  logic [3:0]             cmd_id,
    input  logic [7:0]             size,
    input  logic [8*BUF_BYTES-1:0] wbuf,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [7:0]             err_code,
    output logic [8*BUF_BYTES-1:0] rbuf
);

    logic             dec_ok;
    op_e              dec_op;
    logic [CNT_W-1:0] dec_cnt;
    logic [7:0]       dec_ec;
    logic             rf_we;
    logic [REG_AW-1:0] rf_addr;
    logic [7:0]       rf_wdata, rf_rdata;

    pwr_eng_decode #(.MAX_REGS(MAX_REGS), .CNT_W(CNT_W)) dec_i (
        .cmd_code (cmd_code),
        .cmd_id   (cmd_id),
        .size     (size),
        .ok       (dec_ok),
        .op       (dec_op),
        .cnt      (dec_cnt),
        .ec       (dec_ec)
    );

    pwr_eng_seq #(
        .MAX_REGS (MAX_REGS),
        .BUF_BYTES(BUF_BYTES),
        .REG_AW   (REG_AW),
        .CNT_W    (CNT_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ok       (dec_ok),
        .op       (dec_op),
        .cnt      (dec_cnt),
        .ec       (dec_ec),
        .wbuf     (wbuf),
        .rd_data  (rf_rdata),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .err_code (err_code),
        .rbuf     (rbuf),
        .rf_we    (rf_we),
        .rf_addr  (rf_addr),
        .rf_wdata (rf_wdata)
    );

    pwr_eng_regfile #(.REG_AW(REG_AW)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .addr  (rf_addr),
        .wdata (rf_wdata),
        .rdata (rf_rdata)
    );

endmodule

// File: rtl/pwr_reg_engine_chk.sv
// Module: pwr_reg_engine_chk
// Holds the timing and protocol properties of the command engine. It is
// attached to the top module through bind. Assumes: the reset is synchronous
// and active low.
module pwr_reg_engine_chk #(
    parameter int MAX_REGS = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] cmd_code,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [7:0] err_code,
    input logic       rf_we
);

    logic [7:0] busy_run;

    // Purpose: count how many cycles in a row busy has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= 8'd0;
        else        busy_run <= busy ? busy_run + 8'd1 : 8'd0;
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> $onehot({busy, done}));

    p_no_access_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd_code != 8'hFF) |=> (!rf_we && !busy && err));

    p_err_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (err_code == 8'h01 || err_code == 8'h02 || err_code == 8'h03));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 8'(MAX_REGS));

    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(err) && $stable(err_code)));

    p_ok_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (err_code == 8'h00));

endmodule

bind pwr_reg_engine pwr_reg_engine_chk #(.MAX_REGS(MAX_REGS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd_code (cmd_code),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .err_code (err_code),
    .rf_we    (rf_we)
);

// File: tb/pwr_reg_engine_tb_top.sv
`timescale 1ns/1ps
// Bench for the power register command engine: directed corner cases followed
// by seeded random commands, each judged against a register model kept here.
module pwr_reg_engine_tb_top;

    localparam int AW = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   cmd_code = 8'h00;
    logic [3:0]   cmd_id = 4'h0;
    logic [7:0]   size = 8'h00;
    logic [127:0] wbuf = '0;
    logic         busy, done, err;
    logic [7:0]   err_code;
    logic [127:0] rbuf;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0]   model [1 << AW];
    logic [127:0] exp_rbuf = '0;
    logic         exp_err = 1'b0;
    logic [7:0]   exp_ec_q = 8'h00;

    always #4 clk = ~clk;

    pwr_reg_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
        .cmd_id(cmd_id), .size(size), .wbuf(wbuf), .busy(busy), .done(done),
        .err(err), .err_code(err_code), .rbuf(rbuf)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R8 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_cnt(input logic [3:0] id, input logic [7:0] sz);
        if (id == 4'd0 && sz != 0 && sz % 3 == 0 && sz / 3 <= 5) return sz / 3;
        if (id == 4'd1 && sz != 0 && sz % 2 == 0 && sz / 2 <= 5) return sz / 2;
        if (id == 4'd2 && sz == 8'd4) return 1;
        return 0;
    endfunction

    function automatic logic [7:0] exp_ec(input logic [7:0] code, input logic [3:0] id,
                                          input logic [7:0] sz);
        if (code != 8'hFF) return 8'h01;
        if (id > 4'd2)     return 8'h02;
        if (exp_cnt(id, sz) == 0) return 8'h03;
        return 8'h00;
    endfunction

    function automatic logic [AW-1:0] addr_of(input logic [127:0] wb, input int k);
        logic [15:0] a;
        a = wb[16*k +: 16];
        return a[AW-1:0];
    endfunction

    // Issues one command at the current negative edge and judges its outcome.
    task automatic run_cmd(input logic [7:0] code, input logic [3:0] id, input logic [7:0] sz,
                           input logic [127:0] wb, input bit poke, input string rtag);
        logic [7:0]   ec;
        logic [127:0] er;
        logic [7:0]   old;
        int n, lat, exp_lat;
        ec = exp_ec(code, id, sz);
        n  = exp_cnt(id, sz);
        er = exp_rbuf;
        exp_lat = ((ec == 8'h00) ? n : 0) + 1;
        if (ec == 8'h00) begin
            case (id)
                4'd0: for (int k = 0; k < n; k++) model[addr_of(wb, k)] = wb[8*(2*n+k) +: 8];
                4'd1: begin
                    er = '0;
                    for (int k = 0; k < n; k++) er[8*k +: 8] = model[addr_of(wb, k)];
                end
                default: begin
                    old = model[addr_of(wb, 0)];
                    model[addr_of(wb, 0)] = (old & ~wb[31:24]) | (wb[23:16] & wb[31:24]);
                end
            endcase
        end
        cmd_code = code; cmd_id = id; size = sz; wbuf = wb; start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (poke && lat == 2) begin
                start = 1'b1; cmd_code = 8'h00; wbuf = ~wb;  // R1: must be ignored
            end else begin
                start = 1'b0;
            end
        end while (!done && lat < 20);
        chk($sformatf("R8 latency id=%0d size=%0d", id, sz), 128'(lat), 128'(exp_lat));
        chk("R11 err flag", {127'd0, err}, {127'd0, ec != 8'h00});
        chk(ec == 8'h01 ? "R2 code" : ec == 8'h02 ? "R3 code" : ec == 8'h03 ? "R4 code" : "R11 code",
            {120'd0, err_code}, {120'd0, ec});
        chk($sformatf("%s rbuf", rtag), rbuf, er);
        exp_rbuf = er;
        exp_err  = (ec != 8'h00);
        exp_ec_q = ec;
    endtask

    // Idles with start low and checks that done stays a pulse and the error fields hold.
    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R8 done low after pulse", {127'd0, done}, 128'd0);
            chk("R11 err held", {119'd0, err, err_code}, {119'd0, exp_err, exp_ec_q});
        end
    endtask

    function automatic logic [127:0] rd_list(input logic [15:0] a0, input logic [15:0] a1,
                                             input logic [15:0] a2, input logic [15:0] a3,
                                             input logic [15:0] a4);
        return {48'h0, a4, a3, a2, a1, a0};
    endfunction

    initial begin
        logic [127:0] wb;
        int r, n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 busy/done/err", {125'd0, busy, done, err}, 128'd0);
        chk("R10 err_code", {120'd0, err_code}, 128'd0);
        chk("R10 rbuf", rbuf, 128'd0);
        run_cmd(8'hFF, 4'd1, 8'd10, rd_list(16'd0, 16'd9, 16'd20, 16'd40, 16'd63), 0, "R10 regs zero");

        // R5: write five registers, then read them back
        wb = '0;
        wb[79:0]   = rd_list(16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005);
        wb[119:80] = 40'h55_44_33_22_11;
        run_cmd(8'hFF, 4'd0, 8'd15, wb, 0, "R5 write");
        run_cmd(8'hFF, 4'd1, 8'd10, rd_list(16'h0005, 16'h0001, 16'h0003, 16'h0002, 16'h0004), 0, "R5 readback");
        // R6: short read clears the unused bytes
        run_cmd(8'hFF, 4'd1, 8'd2, {112'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 16'h0003}, 0, "R6 short read");

        // R8: repeated address, later data wins
        wb = '0;
        wb[31:0] = {16'h0010, 16'h0010};
        wb[47:32] = 16'hB2A1;
        run_cmd(8'hFF, 4'd0, 8'd6, wb, 0, "R8 order");
        run_cmd(8'hFF, 4'd1, 8'd2, {112'd0, 16'h0010}, 0, "R8 order readback");

        // R9: upper address bits ignored
        run_cmd(8'hFF, 4'd0, 8'd3, {104'd0, 8'h5A, 16'h1C05}, 0, "R9 write");
        run_cmd(8'hFF, 4'd1, 8'd2, {112'd0, 16'h0005}, 0, "R9 alias read");

        // R7: masked update 0x5A with value 0xF0 under mask 0x3C gives 0x72
        run_cmd(8'hFF, 4'd2, 8'd4, {96'd0, 8'h3C, 8'hF0, 16'hAB05}, 0, "R7 update");
        run_cmd(8'hFF, 4'd1, 8'd2, {112'd0, 16'h0005}, 0, "R7 readback");
        chk("R7 merged value", {120'd0, rbuf[7:0]}, 128'h72);

        // R2, R3, R4: rejected commands, including priority between causes
        run_cmd(8'hFE, 4'd0, 8'd3, {104'd0, 8'h99, 16'h0005}, 0, "R2 bad code");
        run_cmd(8'hFF, 4'd3, 8'd4, {96'd0, 8'hFF, 8'h00, 16'h0005}, 0, "R3 bad id");
        run_cmd(8'h00, 4'd9, 8'd0, '0, 0, "R3 code over id");
        run_cmd(8'hFF, 4'd7, 8'd5, '0, 0, "R4 id over size");
        run_cmd(8'hFF, 4'd0, 8'd5, {104'd0, 8'h99, 16'h0005}, 0, "R4 write size 5");
        run_cmd(8'hFF, 4'd0, 8'd18, {104'd0, 8'h99, 16'h0005}, 0, "R4 write size 18");
        run_cmd(8'hFF, 4'd1, 8'd0, '0, 0, "R4 zero size");
        run_cmd(8'hFF, 4'd1, 8'd12, '0, 0, "R4 read six");
        run_cmd(8'hFF, 4'd2, 8'd3, {96'd0, 8'hFF, 8'h00, 16'h0005}, 0, "R4 update size 3");
        idle(2);
        run_cmd(8'hFF, 4'd1, 8'd2, {112'd0, 16'h0005}, 0, "R2 no access after reject");

        // R1: start during busy is ignored and the captured payload is kept
        wb = '0;
        wb[47:0]   = {16'h0022, 16'h0021, 16'h0020};
        wb[71:48]  = 24'hC3_C2_C1;
        run_cmd(8'hFF, 4'd0, 8'd9, wb, 1, "R1 poke write");
        run_cmd(8'hFF, 4'd1, 8'd6, {80'd0, 16'h0022, 16'h0021, 16'h0020}, 1, "R1 poke readback");

        // Seeded random commands, mostly back to back
        for (int t = 0; t < 400; t++) begin
            wb = {$urandom, $urandom, $urandom, $urandom};
            r = $urandom_range(0, 9);
            n = $urandom_range(1, 5);
            if (r <= 2)
                run_cmd(8'hFF, 4'd0, 8'(3 * n), wb, (n >= 2) && ($urandom_range(0, 4) == 0), "R5 random write");
            else if (r <= 5)
                run_cmd(8'hFF, 4'd1, 8'(2 * n), wb, (n >= 2) && ($urandom_range(0, 4) == 0), "R6 random read");
            else if (r <= 7)
                run_cmd(8'hFF, 4'd2, 8'd4, wb, 0, "R7 random update");
            else if (r == 8)
                run_cmd(8'hFF, 4'($urandom_range(0, 2)), 8'($urandom_range(0, 16)), wb, 0, "R4 random size");
            else
                run_cmd(8'($urandom_range(250, 255)), 4'($urandom_range(0, 15)), 8'd4, wb, 0, "R3 random code/id");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule